// File: doc/BRIEF.md
# Serial Receiver with Two-Word Buffer

This block receives asynchronous serial frames on a single input line and hands each completed word to a host over a small register-style read port. A frame opens with a low start bit. The data bits follow with the least significant bit first. In nine-bit mode one extra bit comes after them. A high stop bit closes the frame. Bit timing comes from an 8-bit divisor followed by a fixed prescale of 16 or 64, picked by a speed-select input.

Each finished word goes into a two-entry buffer. The buffer also stores the word's ninth bit and its framing status. The read port always shows the oldest entry, and a one-cycle read strobe removes that entry. A third word that completes while both entries are still unread raises a sticky overrun flag. That word is lost, and so are any later words until the host clears the flag by dropping the receive enable. The interrupt request is the data-available flag gated by an enable input.

Top module: `serial_rx_fifo`

## Requirements
- R1: In eight-bit mode the eight bits after the start bit appear on `rd_data`, with the first received bit in bit 0.
- R2: With `nine_en` high, the bit after the eighth data bit appears on `rd_bit9` for the same entry.
- R3: A stop bit sampled low sets `rd_ferr` for that entry only. The flag follows the entry at the head of the buffer.
- R4: The buffer holds two words and presents the oldest one. A `rd_pop` pulse removes the oldest word. A `rd_pop` on an empty buffer has no effect.
- R5: A word that completes while two words are held and no pop occurs in that cycle sets `ovr_err` and is discarded. While `ovr_err` is set, every further word is discarded. Driving `rcv_en` low clears `ovr_err`.
- R6: A word that completes in the same cycle as a pop on a full buffer is stored, and `ovr_err` stays low.
- R7: Frames are received only while both `port_en` and `rcv_en` are high. Frames that arrive while either one is low are ignored.
- R8: One bit lasts (`divisor`+1)*16 clock cycles when `fast_sel` is high, and (`divisor`+1)*64 clock cycles when it is low.
- R9: Each bit value is the majority of three samples taken at the middle of the bit, so a single-sample disturbance does not change it. A start bit that reads high at its middle is dropped, and the receiver waits for the next falling edge.
- R10: `rx_avail` is high exactly when the buffer is not empty. `irq` equals `rx_avail` while `irq_en` is high and is low otherwise.
- R11: After reset `rd_data`, `rd_ferr`, `rx_avail`, `ovr_err` and `irq` are all zero. The value of `rd_bit9` after reset is not guaranteed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial input line, idle high |
| port_en | input | 1 | Serial port enable |
| rcv_en | input | 1 | Continuous receive enable; low clears overrun |
| nine_en | input | 1 | Nine data bits per frame when high |
| fast_sel | input | 1 | Prescale 16 when high, 64 when low |
| irq_en | input | 1 | Interrupt enable |
| divisor | input | 8 | Baud divisor; tick period is divisor+1 clocks |
| rd_pop | input | 1 | Read strobe, removes the oldest word |
| rd_data | output | 8 | Data byte of the oldest word |
| rd_bit9 | output | 1 | Ninth bit of the oldest word |
| rd_ferr | output | 1 | Framing error of the oldest word |
| rx_avail | output | 1 | Buffer not empty |
| ovr_err | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The case that needs care is when the completion of a word and a host pop land on the same clock edge while the buffer is full. There, the buffer must accept the new word instead of flagging overrun. The bench provokes this by timing a read strobe so that it is high on the exact edge at which the stop bit of the third frame is judged, counting the synchronizer and prescale delays. It then checks that `ovr_err` stays low, that the head moves to the second word, and that the third word comes out after one more pop. As a counter-case, the same three frames sent without the pop must raise the flag.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             port_en,
  input  logic             rcv_en,
  input  logic             nine_en,
  input  logic             fast_sel,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rd_pop,
  output logic [WORD_W-1:0] rd_data,
  output logic             rd_bit9,
  output logic             rd_ferr,
  output logic             rx_avail,
  output logic             ovr_err,
  output logic             irq
);
  localparam int ENT_W = WORD_W + 2;
  localparam int IDX_W = $clog2(WORD_W + 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [1:0]       sync;
  logic             rx_s;
  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  st_t              state;
  logic [5:0]       phase;
  logic [IDX_W-1:0] bit_idx;
  logic [1:0]       smp;
  logic             bit_v;
  logic [WORD_W:0]  shreg;
  logic [ENT_W-1:0] mem [2];
  logic             wp, rp;
  logic [1:0]       cnt;

  wire enabled = port_en & rcv_en;
  wire [5:0] ph_last = fast_sel ? 6'd15 : 6'd63;
  wire [5:0] ph_mid  = fast_sel ? 6'd8  : 6'd32;
  wire [IDX_W-1:0] idx_last = nine_en ? IDX_W'(WORD_W) : IDX_W'(WORD_W - 1);

  assign rx_s = sync[1];
  assign tick = (div_cnt == divisor);

  wire vote   = (smp[1] & smp[0]) | (smp[1] & rx_s) | (smp[0] & rx_s);
  wire at_vote = tick && (phase == ph_mid + 6'd1);
  wire at_end  = tick && (phase == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      div_cnt <= '0;
    end else begin
      sync    <= {sync[0], rx_in};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= '0;
      bit_idx <= '0;
      smp     <= 2'b11;
      bit_v   <= 1'b1;
      shreg   <= '0;
    end else if (!enabled) begin
      state <= S_IDLE;
      phase <= '0;
    end else begin
      if (tick && (phase == ph_mid - 6'd1 || phase == ph_mid))
        smp <= {smp[0], rx_s};
      if (state != S_IDLE && tick)
        phase <= at_end ? 6'd0 : phase + 6'd1;
      case (state)
        S_IDLE: begin
          phase   <= '0;
          bit_idx <= '0;
          if (!rx_s) state <= S_START;
        end
        S_START: begin
          if (at_vote && vote) state <= S_IDLE;
          else if (at_end)     state <= S_DATA;
        end
        S_DATA: begin
          if (at_vote) bit_v <= vote;
          if (at_end) begin
            shreg   <= {bit_v, shreg[WORD_W:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == idx_last) state <= S_STOP;
          end
        end
        default: begin
          if (at_vote) state <= S_IDLE;
        end
      endcase
    end
  end

  wire [WORD_W-1:0] w_data = nine_en ? shreg[WORD_W-1:0] : shreg[WORD_W:1];
  wire              w_b9   = nine_en & shreg[WORD_W];
  wire              push   = enabled && (state == S_STOP) && at_vote;
  wire              pop    = rd_pop && (cnt != 2'd0);
  wire              store  = push && !ovr_err && (cnt != 2'd2 || pop);
  wire              lose   = push && !ovr_err && (cnt == 2'd2) && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0]  <= '0;
      mem[1]  <= '0;
      wp      <= 1'b0;
      rp      <= 1'b0;
      cnt     <= '0;
      ovr_err <= 1'b0;
    end else begin
      if (pop) rp <= ~rp;
      if (store) begin
        mem[wp] <= {~vote, w_b9, w_data};
        wp      <= ~wp;
      end
      cnt <= cnt + {1'b0, store} - {1'b0, pop};
      if (!rcv_en)   ovr_err <= 1'b0;
      else if (lose) ovr_err <= 1'b1;
    end
  end

  assign {rd_ferr, rd_bit9, rd_data} = mem[rp];
  assign rx_avail = (cnt != 2'd0);
  assign irq      = rx_avail & irq_en;

  p_depth_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2);
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && cnt == 2'd2 && !rd_pop |=> ovr_err);
  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && rcv_en |=> ovr_err);
  p_ovr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !rd_pop |=> $stable(cnt));
  p_same_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && cnt == 2'd2 && rd_pop && !ovr_err |=> cnt == 2'd2 && !ovr_err);
  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && rcv_en) |=> state == S_IDLE);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, port_en = 1'b0, rcv_en = 1'b0, nine_en = 1'b0;
  logic fast_sel = 1'b1, irq_en = 1'b0, rd_pop = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, rx_avail, ovr_err, irq;
  int total = 0, bad = 0, bc = 16;

  always #10 clk = ~clk;

  serial_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .port_en(port_en), .rcv_en(rcv_en),
    .nine_en(nine_en), .fast_sel(fast_sel), .irq_en(irq_en), .divisor(divisor),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .rx_avail(rx_avail), .ovr_err(ovr_err), .irq(irq)
  );

  // {nine_en, bad_stop, nine-bit payload}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 9'h0A5}, {1'b0, 1'b0, 9'h03C}, {1'b1, 1'b0, 9'h1C3},
    {1'b1, 1'b0, 9'h05A}, {1'b0, 1'b1, 9'h0FF}, {1'b1, 1'b1, 9'h100}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stop_ok,
                      input int glitch_bit, input int pop_at);
    int nd = nine ? 9 : 8;
    for (int n = 0; n < (nd + 2) * bc; n++) begin
      int k = n / bc;
      logic lvl;
      @(negedge clk);
      if (k == 0) lvl = 1'b0;
      else if (k <= nd) lvl = d[k-1];
      else lvl = stop_ok;
      if (k == glitch_bit && (n % bc) == 10) lvl = ~lvl;
      rx_in  = lvl;
      rd_pop = (n == pop_at);
    end
    @(negedge clk);
    rx_in = 1'b1;
    rd_pop = 1'b0;
    repeat (3 * bc) @(negedge clk);
  endtask

  task automatic pop1();
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 data", rd_data, 0);
    check("R11 ferr", rd_ferr, 0);
    check("R11 avail", rx_avail, 0);
    check("R11 ovr", ovr_err, 0);
    check("R11 irq", irq, 0);
    rst_n = 1'b1;
    port_en = 1'b1; rcv_en = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      nine_en = VEC[i][10];
      irq_en  = i[0];
      send(VEC[i][8:0], VEC[i][10], !VEC[i][9], -1, -1);
      check("R10 avail", rx_avail, 1);
      check("R10 irq", irq, i % 2);
      check("R1 data", rd_data, VEC[i][10] ? VEC[i][7:0] : VEC[i][7:0]);
      if (VEC[i][10]) check("R2 bit9", rd_bit9, VEC[i][8]);
      check("R3 ferr", rd_ferr, VEC[i][9]);
      pop1();
      @(negedge clk);
      check("R4 drained", rx_avail, 0);
    end
    nine_en = 1'b0; irq_en = 1'b0;

    // R3: flags travel with their entry
    send(9'h011, 0, 0, -1, -1);
    send(9'h022, 0, 1, -1, -1);
    check("R3 head ferr", rd_ferr, 1);
    pop1(); @(negedge clk);
    check("R3 next ferr", rd_ferr, 0);
    check("R3 next data", rd_data, 8'h22);
    pop1();
    // R4: pop on empty ignored
    pop1(); @(negedge clk);
    check("R4 empty pop", rx_avail, 0);
    send(9'h0C7, 0, 1, -1, -1);
    check("R4 after empty pop", rd_data, 8'hC7);
    pop1();

    // R5: overrun
    send(9'h0A1, 0, 1, -1, -1);
    send(9'h0A2, 0, 1, -1, -1);
    send(9'h0A3, 0, 1, -1, -1);
    check("R5 ovr set", ovr_err, 1);
    check("R5 head kept", rd_data, 8'hA1);
    send(9'h0A4, 0, 1, -1, -1);
    pop1(); @(negedge clk);
    check("R5 second", rd_data, 8'hA2);
    pop1(); @(negedge clk);
    check("R5 dropped", rx_avail, 0);
    check("R5 still set", ovr_err, 1);
    rcv_en = 1'b0; @(negedge clk); @(negedge clk);
    check("R5 cleared", ovr_err, 0);
    rcv_en = 1'b1; repeat (4) @(negedge clk);

    // R6: pop on the completion edge of a third word
    send(9'h0B1, 0, 1, -1, -1);
    send(9'h0B2, 0, 1, -1, -1);
    send(9'h0B3, 0, 1, -1, 156);
    check("R6 no ovr", ovr_err, 0);
    check("R6 head", rd_data, 8'hB2);
    pop1(); @(negedge clk);
    check("R6 third", rd_data, 8'hB3);
    pop1();

    // R7: disabled paths
    port_en = 1'b0;
    send(9'h055, 0, 1, -1, -1);
    check("R7 port off", rx_avail, 0);
    port_en = 1'b1; rcv_en = 1'b0;
    send(9'h055, 0, 1, -1, -1);
    check("R7 rcv off", rx_avail, 0);
    rcv_en = 1'b1; repeat (4) @(negedge clk);

    // R9: single-sample disturbance and start glitch
    send(9'h000, 0, 1, 2, -1);
    check("R9 vote", rd_data, 8'h00);
    pop1();
    send(9'h0FF, 0, 1, 5, -1);
    check("R9 vote hi", rd_data, 8'hFF);
    pop1();
    @(negedge clk); rx_in = 1'b0;
    repeat (4) @(negedge clk); rx_in = 1'b1;
    repeat (200) @(negedge clk);
    check("R9 start glitch", rx_avail, 0);
    send(9'h069, 0, 1, -1, -1);
    check("R9 resync", rd_data, 8'h69);
    pop1();

    // R8: divisor and prescale
    fast_sel = 1'b0; divisor = 8'd1; bc = 128;
    repeat (300) @(negedge clk);
    send(9'h096, 0, 1, -1, -1);
    check("R8 div64", rd_data, 8'h96);
    pop1();
    fast_sel = 1'b1; divisor = 8'd2; bc = 48;
    repeat (300) @(negedge clk);
    send(9'h1E, 0, 1, -1, -1);
    check("R8 div16", rd_data, 8'h1E);
    pop1();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule